// File: doc/BRIEF.md
# DMA Peripheral Request Router

This block decides which on-chip peripheral event starts a DMA channel. Four peripheral request lines come in: serial transmit-empty, serial receive-full, converter-done and timer match. A 4-bit select field chooses at most one of them. The chosen line stops reaching the CPU as an interrupt. Its rising edge becomes a pending transfer request toward the DMA engine, and that request stays up until the engine acknowledges it.

A request is forwarded only while five channel status conditions allow it, and only when the transfer setup suits the chosen requester. The setup covers the transfer size and the address-class tags of the source and the target. When the setup is wrong for the chosen requester, a configuration-error flag is raised and nothing is forwarded. Every output is registered, so each one follows its inputs by one clock.

Top module: `dma_req_router`

## Requirements
- R1: Select codes 4'b1011, 4'b1101, 4'b1110 and 4'b1111 choose request bit 0 (serial transmit-empty), bit 1 (serial receive-full), bit 2 (converter done) and bit 3 (timer match). Any other code chooses nothing, and with nothing chosen `cfg_err_o` and `dma_req_o` stay 0.
- R2: A request is accepted only while `chan_en_i`=1, `master_en_i`=1, `xfer_end_i`=0, `addr_err_i`=0 and `nmi_i`=0. If any one of these conditions is off, a rising edge on the chosen line produces no request.
- R3: A rising edge on the chosen line, while the request is accepted, sets `dma_req_o` one clock later. `dma_req_o` holds until a clock with `dma_ack_i`=1 clears it. `dma_req_o` is 0 after reset.
- R4: A second edge that arrives while a request is pending merges with it, so a single acknowledge clears both. An edge in the same clock as the acknowledge keeps the request pending.
- R5: Size code 2'b11 (16-byte transfer) with any peripheral chosen sets `cfg_err_o` one clock later and blocks the request.
- R6: With receive-full chosen, a source tag other than 3'd4 (serial receive data) is an error.
- R7: With transmit-empty chosen, a target tag other than 3'd3 (serial transmit data) is an error.
- R8: With converter-done chosen, a source tag other than 3'd5 (converter result) is an error. Timer match accepts any permitted source and target tags.
- R9: Source or target tags 3'd6 and 3'd7 (controller-internal classes) are an error for any chosen peripheral.
- R10: `cpu_irq_o` equals the request lines with the chosen bit cleared, delayed by one clock. With nothing chosen, all four lines pass through.
- R11: A line held high after its request is acknowledged does not raise a new request.
- R12: A pending request is dropped in the clock after the request stops being accepted, for any of these causes: a disabling flag, an error, or a cleared selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| periph_req_i | input | 4 | Peripheral request lines: bit 0 transmit-empty, bit 1 receive-full, bit 2 converter done, bit 3 timer match |
| req_sel_i | input | 4 | Requester select code |
| chan_en_i | input | 1 | Channel enable |
| master_en_i | input | 1 | Controller-wide enable |
| xfer_end_i | input | 1 | Transfer-finished status |
| addr_err_i | input | 1 | Address fault status |
| nmi_i | input | 1 | Non-maskable interrupt status |
| xfer_size_i | input | 2 | Transfer size code; 2'b11 is 16 bytes |
| src_tag_i | input | 3 | Source address-class tag |
| dst_tag_i | input | 3 | Target address-class tag |
| dma_ack_i | input | 1 | DMA engine acknowledges the pending request |
| dma_req_o | output | 1 | Pending transfer request |
| cpu_irq_o | output | 4 | Peripheral interrupts passed to the CPU |
| cfg_err_o | output | 1 | Setup illegal for the chosen requester |

## Verification
The collision that matters is a new edge on the chosen line arriving in the same clock as the engine's acknowledge. If the set-and-clear order is wrong, that second event is lost. The bench first makes a request pending and drops the line for one clock. It then raises the line and the acknowledge together, and expects `dma_req_o` still high on the next clock. A further acknowledge with no new edge must then clear it.

// File: rtl/dma_rtr_pkg.sv
package dma_rtr_pkg;
  localparam int NPER   = 4;
  localparam int SEL_W  = 4;
  localparam int SIZE_W = 2;
  localparam int TAG_W  = 3;

  typedef enum int {
    PER_TX  = 0,
    PER_RX  = 1,
    PER_ADC = 2,
    PER_TMR = 3
  } per_idx_e;

  localparam logic [SEL_W-1:0] CODE_TX  = 4'b1011;
  localparam logic [SEL_W-1:0] CODE_RX  = 4'b1101;
  localparam logic [SEL_W-1:0] CODE_ADC = 4'b1110;
  localparam logic [SEL_W-1:0] CODE_TMR = 4'b1111;

  localparam logic [SIZE_W-1:0] SIZE_16B = 2'b11;

  localparam logic [TAG_W-1:0] TAG_TXD      = 3'd3;
  localparam logic [TAG_W-1:0] TAG_RXD      = 3'd4;
  localparam logic [TAG_W-1:0] TAG_ADD      = 3'd5;
  localparam logic [TAG_W-1:0] TAG_CTRL_MIN = 3'd6;
endpackage

// File: rtl/rtr_decode.sv
module rtr_decode
  import dma_rtr_pkg::*;
#(
  parameter int N_PER = NPER,
  parameter int SW    = SEL_W
) (
  input  logic [SW-1:0]    sel_code,
  output logic [N_PER-1:0] sel_vec,
  output logic             sel_any
);
  localparam logic [SW-1:0] CODES [4] = '{CODE_TX, CODE_RX, CODE_ADC, CODE_TMR};

  for (genvar i = 0; i < N_PER; i++) begin : g_dec
    assign sel_vec[i] = (sel_code == CODES[i]);
  end

  assign sel_any = |sel_vec;
endmodule

// File: rtl/rtr_legal.sv
module rtr_legal
  import dma_rtr_pkg::*;
#(
  parameter int N_PER = NPER,
  parameter int ZW    = SIZE_W,
  parameter int TW    = TAG_W
) (
  input  logic [N_PER-1:0] sel_vec,
  input  logic [ZW-1:0]    size,
  input  logic [TW-1:0]    src_tag,
  input  logic [TW-1:0]    dst_tag,
  output logic             ok
);
  logic size_bad, tag_bad, rx_bad, tx_bad, adc_bad;

  always_comb begin
    size_bad = (size == SIZE_16B);
    tag_bad  = (src_tag >= TAG_CTRL_MIN) || (dst_tag >= TAG_CTRL_MIN);
    rx_bad   = sel_vec[PER_RX]  && (src_tag != TAG_RXD);
    tx_bad   = sel_vec[PER_TX]  && (dst_tag != TAG_TXD);
    adc_bad  = sel_vec[PER_ADC] && (src_tag != TAG_ADD);
    ok       = !(size_bad || tag_bad || rx_bad || tx_bad || adc_bad);
  end
endmodule

// File: rtl/rtr_pending.sv
module rtr_pending #(
  parameter int N_PER = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_PER-1:0] req_lines,
  input  logic [N_PER-1:0] sel_vec,
  input  logic             qual,
  input  logic             ack,
  output logic             pend
);
  logic [N_PER-1:0] prev_q;
  logic             rise_sel;
  logic             pend_d;

  always_comb begin
    rise_sel = |(req_lines & ~prev_q & sel_vec);
    pend_d   = qual && ((pend && !ack) || rise_sel);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pend   <= 1'b0;
    end else begin
      prev_q <= req_lines;
      pend   <= pend_d;
    end
  end

  AST_HOLD_TILL_ACK: assert property (@(posedge clk) disable iff (rst)
    (pend && !ack && qual) |=> pend); // R3
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (pend && ack && !rise_sel) |=> !pend); // R3
  AST_EDGE_WINS_ACK: assert property (@(posedge clk) disable iff (rst)
    (qual && rise_sel && ack) |=> pend); // R4
  AST_DROP_UNQUAL: assert property (@(posedge clk) disable iff (rst)
    !qual |=> !pend); // R12
endmodule

// File: rtl/dma_req_router.sv
module dma_req_router
  import dma_rtr_pkg::*;
#(
  parameter int N_PER = NPER,
  parameter int SW    = SEL_W,
  parameter int ZW    = SIZE_W,
  parameter int TW    = TAG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_PER-1:0] periph_req_i,
  input  logic [SW-1:0]    req_sel_i,
  input  logic             chan_en_i,
  input  logic             master_en_i,
  input  logic             xfer_end_i,
  input  logic             addr_err_i,
  input  logic             nmi_i,
  input  logic [ZW-1:0]    xfer_size_i,
  input  logic [TW-1:0]    src_tag_i,
  input  logic [TW-1:0]    dst_tag_i,
  input  logic             dma_ack_i,
  output logic             dma_req_o,
  output logic [N_PER-1:0] cpu_irq_o,
  output logic             cfg_err_o
);
  logic [N_PER-1:0] sel_vec;
  logic             sel_any;
  logic             legal_ok;
  logic             run_ok;
  logic             qual;

  rtr_decode #(.N_PER(N_PER), .SW(SW)) u_dec (
    .sel_code (req_sel_i),
    .sel_vec  (sel_vec),
    .sel_any  (sel_any)
  );

  rtr_legal #(.N_PER(N_PER), .ZW(ZW), .TW(TW)) u_legal (
    .sel_vec (sel_vec),
    .size    (xfer_size_i),
    .src_tag (src_tag_i),
    .dst_tag (dst_tag_i),
    .ok      (legal_ok)
  );

  assign run_ok = chan_en_i && master_en_i && !xfer_end_i && !addr_err_i && !nmi_i;
  assign qual   = run_ok && legal_ok && sel_any;

  rtr_pending #(.N_PER(N_PER)) u_pend (
    .clk       (clk),
    .rst       (rst),
    .req_lines (periph_req_i),
    .sel_vec   (sel_vec),
    .qual      (qual),
    .ack       (dma_ack_i),
    .pend      (dma_req_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_irq_o <= '0;
      cfg_err_o <= 1'b0;
    end else begin
      cpu_irq_o <= periph_req_i & ~sel_vec;
      cfg_err_o <= sel_any && !legal_ok;
    end
  end

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (cpu_irq_o & $past(sel_vec)) == '0); // R10
  AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    cfg_err_o |-> !dma_req_o); // R5
  AST_SIZE_ERR: assert property (@(posedge clk) disable iff (rst)
    (sel_any && xfer_size_i == SIZE_16B) |=> (cfg_err_o && !dma_req_o)); // R5
  AST_CTRL_TAG_ERR: assert property (@(posedge clk) disable iff (rst)
    (sel_any && (src_tag_i >= TAG_CTRL_MIN || dst_tag_i >= TAG_CTRL_MIN)) |=> cfg_err_o); // R9
  AST_NOSEL_QUIET: assert property (@(posedge clk) disable iff (rst)
    !sel_any |=> (!cfg_err_o && !dma_req_o)); // R1
endmodule

// File: tb/tb_dma_req_router.sv
`timescale 1ns/1ps
module tb_dma_req_router;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] req = '0;
  logic [3:0] sel = 4'b1011;
  logic       chan_en = 1'b1, mst_en = 1'b1, xend = 1'b0, aerr = 1'b0, nmi = 1'b0;
  logic [1:0] size = 2'b00;
  logic [2:0] st = 3'd0, dt = 3'd3;
  logic       ack = 1'b0;
  logic       dma_req_o, cfg_err_o;
  logic [3:0] cpu_irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  dma_req_router dut (
    .clk(clk), .rst(rst), .periph_req_i(req), .req_sel_i(sel),
    .chan_en_i(chan_en), .master_en_i(mst_en), .xfer_end_i(xend),
    .addr_err_i(aerr), .nmi_i(nmi), .xfer_size_i(size),
    .src_tag_i(st), .dst_tag_i(dt), .dma_ack_i(ack),
    .dma_req_o(dma_req_o), .cpu_irq_o(cpu_irq_o), .cfg_err_o(cfg_err_o)
  );

  // fields: sel[21:18] size[17:16] src[15:13] dst[12:10] req[9:6] err[5] irq[4:1] dma[0]
  localparam logic [21:0] VEC [12] = '{
    {4'b1011, 2'b00, 3'd0, 3'd3, 4'b1111, 1'b0, 4'b1110, 1'b1}, // R1 R7 R10 transmit ok
    {4'b1011, 2'b00, 3'd0, 3'd0, 4'b0001, 1'b1, 4'b0000, 1'b0}, // R7 wrong target
    {4'b1101, 2'b00, 3'd4, 3'd0, 4'b1111, 1'b0, 4'b1101, 1'b1}, // R6 receive ok
    {4'b1101, 2'b00, 3'd0, 3'd0, 4'b0010, 1'b1, 4'b0000, 1'b0}, // R6 wrong source
    {4'b1110, 2'b00, 3'd5, 3'd1, 4'b1111, 1'b0, 4'b1011, 1'b1}, // R8 converter ok
    {4'b1110, 2'b01, 3'd2, 3'd1, 4'b0100, 1'b1, 4'b0000, 1'b0}, // R8 wrong source
    {4'b1111, 2'b10, 3'd1, 3'd2, 4'b1111, 1'b0, 4'b0111, 1'b1}, // R8 timer any tags
    {4'b1111, 2'b11, 3'd0, 3'd0, 4'b1000, 1'b1, 4'b0000, 1'b0}, // R5 16-byte
    {4'b1111, 2'b00, 3'd6, 3'd0, 4'b1000, 1'b1, 4'b0000, 1'b0}, // R9 source tag
    {4'b1111, 2'b00, 3'd0, 3'd7, 4'b1000, 1'b1, 4'b0000, 1'b0}, // R9 target tag
    {4'b0000, 2'b11, 3'd6, 3'd7, 4'b1111, 1'b0, 4'b1111, 1'b0}, // R1 R10 no selection
    {4'b1010, 2'b00, 3'd0, 3'd0, 4'b0101, 1'b0, 4'b0101, 1'b0}  // R1 unlisted code
  };

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic set_good();
    chan_en = 1'b1; mst_en = 1'b1; xend = 1'b0; aerr = 1'b0; nmi = 1'b0;
    sel = 4'b1011; size = 2'b00; st = 3'd0; dt = 3'd3; ack = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) step();
    chk("R3 reset dma_req", {3'b0, dma_req_o}, 4'b0);
    chk("R10 reset cpu_irq", cpu_irq_o, 4'b0);
    chk("R5 reset cfg_err", {3'b0, cfg_err_o}, 4'b0);
    rst = 1'b0;
    step();

    // table walk
    foreach (VEC[i]) begin
      set_good();
      sel = VEC[i][21:18]; size = VEC[i][17:16]; st = VEC[i][15:13]; dt = VEC[i][12:10];
      req = 4'b0000;
      step();
      req = VEC[i][9:6];
      step();
      chk($sformatf("R5-table err v%0d", i), {3'b0, cfg_err_o}, {3'b0, VEC[i][5]});
      chk($sformatf("R10 table irq v%0d", i), cpu_irq_o, VEC[i][4:1]);
      chk($sformatf("R3 table dma v%0d", i), {3'b0, dma_req_o}, {3'b0, VEC[i][0]});
      ack = 1'b1; req = 4'b0000;
      step();
      ack = 1'b0;
      step();
    end

    // R2: each disabling flag blocks a request
    for (int k = 0; k < 5; k++) begin
      set_good();
      case (k)
        0: chan_en = 1'b0;
        1: mst_en  = 1'b0;
        2: xend    = 1'b1;
        3: aerr    = 1'b1;
        default: nmi = 1'b1;
      endcase
      req = 4'b0000;
      step();
      req = 4'b0001;
      step();
      chk($sformatf("R2 flag %0d", k), {3'b0, dma_req_o}, 4'b0);
      set_good();
      req = 4'b0000;
      step();
      step();
    end

    // R3 hold until ack, R11 no re-request on held level
    set_good();
    req = 4'b0001;
    step();
    chk("R3 set", {3'b0, dma_req_o}, 4'b1);
    step(); step(); step();
    chk("R3 hold", {3'b0, dma_req_o}, 4'b1);
    ack = 1'b1;
    step();
    ack = 1'b0;
    chk("R3 cleared by ack", {3'b0, dma_req_o}, 4'b0);
    step(); step();
    chk("R11 held level", {3'b0, dma_req_o}, 4'b0);

    // R4 merge: two edges, one ack
    req = 4'b0000; step();
    req = 4'b0001; step();
    req = 4'b0000; step();
    req = 4'b0001; step();
    chk("R4 merged pending", {3'b0, dma_req_o}, 4'b1);
    ack = 1'b1; step(); ack = 1'b0;
    chk("R4 one ack clears", {3'b0, dma_req_o}, 4'b0);

    // R4 edge and ack in the same clock
    req = 4'b0000; step();
    req = 4'b0001; step();
    req = 4'b0000; step();
    req = 4'b0001; ack = 1'b1; step(); ack = 1'b0;
    chk("R4 edge with ack", {3'b0, dma_req_o}, 4'b1);
    ack = 1'b1; step(); ack = 1'b0;
    chk("R4 later ack clears", {3'b0, dma_req_o}, 4'b0);

    // R12 drop on disable, no revival on re-enable
    req = 4'b0000; step();
    req = 4'b0001; step();
    chk("R12 pending", {3'b0, dma_req_o}, 4'b1);
    chan_en = 1'b0; step();
    chk("R12 dropped", {3'b0, dma_req_o}, 4'b0);
    chan_en = 1'b1; step();
    chk("R12 stays low", {3'b0, dma_req_o}, 4'b0);

    // R12 drop on selection cleared
    req = 4'b0000; step();
    req = 4'b0001; step();
    sel = 4'b0000; step();
    chk("R12 sel cleared", {3'b0, dma_req_o}, 4'b0);
    chk("R10 pass all", cpu_irq_o, 4'b0001);

    finish_run();
  end
endmodule